// File: doc/BRIEF.md
# Byte-Protocol Two-Wire Slave with Dual Output Configurations

This block is a two-wire serial slave that understands only the single-byte write and single-byte read transfers. It drives three open-drain lines, each through an active-low pull enable. Every written byte is stored in one of two configuration slots: the "normal" slot or the "hold" slot. Bit 7 of the byte chooses the slot. A separate level input, `hold_sel_i`, picks which slot drives the lines. That input reaches the lines through combinational logic, so a platform can switch between two stored line patterns without waiting for a bus transfer.

A read returns the live levels of the three lines and a thermal-fault flag. The thermal flag arrives as a digital input. While it is set, all three lines are released. The slave address is one of three parameter values. The three-state address-select input picks among them, and it is sampled only while reset is held. The system clock oversamples SCL and SDA through two-flop synchronizers and an edge detector.

The protocol state machine has six states:
- `ST_IDLE`: off the bus.
- `ST_ADDR`: shifting in the address and the R/W bit.
- `ST_ACK_A`: acknowledging the address.
- `ST_WR`: shifting in the data byte.
- `ST_ACK_W`: acknowledging the data byte and committing it.
- `ST_RD`: shifting out the read byte.

Its transitions are:
- Any state goes to `ST_ADDR` on START.
- Any state goes to `ST_IDLE` on STOP.
- `ST_ADDR` goes to `ST_ACK_A` on the SCL fall after 8 bits when the address matches, and to `ST_IDLE` when it does not.
- `ST_ACK_A` goes to `ST_WR` (write) or `ST_RD` (read) on the next SCL fall.
- `ST_WR` goes to `ST_ACK_W` on the SCL fall after 8 bits.
- `ST_ACK_W` goes to `ST_IDLE` on the next SCL fall.
- `ST_RD` goes to `ST_IDLE` on the SCL fall that ends the eighth bit.

Top module: `smb_dualcfg_slave`

## Requirements
- R1: In reset and right after it, both slots hold all ones when `RST_OFF`=1 (or all zeros when `RST_OFF`=0). With the default `RST_OFF`=1, `out_low_o` is 3'b000 and `sda_drive_low_o` is 0.
- R2: After START, the slave acknowledges (drives SDA low for the ninth clock) only when the 7 address bits match its own address. On a mismatch it leaves SDA released until the next START. A read from a wrong address therefore sees 8'hFF.
- R3: The address is taken from `addr_sel_i` while `rst_n` is low: 2'b00 gives `ADDR_LOW` (default 7'h20), 2'b10 gives `ADDR_HIGH` (7'h48), and 2'b01 or 2'b11 give `ADDR_MID` (7'h3C). Changing `addr_sel_i` after reset has no effect.
- R4: In a write, data bit 7 = 1 stores bits 2:0 into the normal slot and bit 7 = 0 stores them into the hold slot. Bits 2:0 map to lines 3..1, and `out_low_o[k]` = 1 (line pulled low) when stored bit k is 0. Bits 6:3 are accepted but not stored. A write to one slot leaves the other unchanged.
- R5: With `hold_sel_i` = 1 the normal slot drives `out_low_o`, and with `hold_sel_i` = 0 the hold slot drives it. The path is combinational, so a change appears in the same cycle.
- R6: A write is acknowledged after the address byte and again after the data byte. The data takes effect on the SCL rise of the second acknowledge clock, and not before it.
- R7: A START or STOP that arrives before all 8 data bits have been received discards the write, and neither slot changes.
- R8: The read byte is {4'b0000, `therm_i`, `pin_i[2:0]`}, sent MSB first. It is sampled at the SCL fall that ends the address acknowledge, so every read reflects the levels at that moment.
- R9: While `therm_i` = 1, `out_low_o` = 3'b000 regardless of slot contents.
- R10: `sda_drive_low_o` changes only while SCL is low during a well-formed transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset; address select is sampled while low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus) |
| sda_drive_low_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| addr_sel_i | input | 2 | Three-level address select: 00 low, 01/11 floating, 10 high |
| hold_sel_i | input | 1 | 1 = normal slot drives lines, 0 = hold slot |
| therm_i | input | 1 | Thermal fault flag; forces all lines released |
| pin_i | input | 3 | Live levels of lines 3..1 for read-back |
| out_low_o | output | 3 | 1 = pull corresponding line low |

## Verification
A bus edge is recognised two to three system clocks after the line changes. A response on SDA is registered on the next clock. A committed write reaches its slot one clock after the commit strobe. `hold_sel_i` and `therm_i` reach `out_low_o` in the same cycle. The bench holds every SCL phase for six system clocks and samples SDA and the outputs on falling clock edges at the end of a phase. That way each result is due well before it is read. The split acknowledge checks the output once at the end of the low phase, where it must still hold the old value, and once at the end of the high phase, where it must hold the new value.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;
    localparam int IO_N   = 3;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_A,
        ST_WR,
        ST_ACK_W,
        ST_RD
    } smb_state_e;

    function automatic logic [ADDR_W-1:0] pick_addr(input logic [1:0] sel,
                                                   input logic [ADDR_W-1:0] lo,
                                                   input logic [ADDR_W-1:0] mid,
                                                   input logic [ADDR_W-1:0] hi);
        case (sel)
            2'b00:   return lo;
            2'b10:   return hi;
            default: return mid;
        endcase
    endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o,
    output logic [LINES-1:0] prv_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [2:0] pipe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= 3'b111;
            else        pipe_q <= {pipe_q[1:0], raw_i[g]};
        end
        assign lvl_o[g] = pipe_q[1];
        assign prv_o[g] = pipe_q[2];
    end
endmodule

// File: rtl/smb_byte_fsm.sv
module smb_byte_fsm
    import smbcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_prv,
    input  logic              sda_lvl,
    input  logic              sda_prv,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [BYTE_W-1:0] rd_val,
    output logic              sda_low_o,
    output logic              wr_stb_o,
    output logic              wr_tgt_o,
    output logic [IO_N-1:0]   wr_bits_o,
    output smb_state_e        state_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    smb_state_e        state_q, state_d;
    logic [BYTE_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;

    wire scl_rise = scl_lvl & ~scl_prv;
    wire scl_fall = ~scl_lvl & scl_prv;
    wire start_ev = scl_lvl & scl_prv & sda_prv & ~sda_lvl;
    wire stop_ev  = scl_lvl & scl_prv & ~sda_prv & sda_lvl;
    wire match    = (shreg_q[BYTE_W-1:1] == own_addr);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (start_ev) begin
            state_d = ST_ADDR;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ADDR:  if (scl_fall && cnt_q == CNT_FULL) state_d = match ? ST_ACK_A : ST_IDLE;
                ST_ACK_A: if (scl_fall) state_d = shreg_q[0] ? ST_RD : ST_WR;
                ST_WR:    if (scl_fall && cnt_q == CNT_FULL) state_d = ST_ACK_W;
                ST_ACK_W: if (scl_fall) state_d = ST_IDLE;
                ST_RD:    if (scl_fall && cnt_q == CNT_LAST) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            cnt_q     <= '0;
            sda_low_o <= 1'b0;
            wr_stb_o  <= 1'b0;
        end else begin
            wr_stb_o <= 1'b0;
            if (start_ev) begin
                cnt_q     <= '0;
                sda_low_o <= 1'b0;
            end else if (stop_ev) begin
                sda_low_o <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl};
                            cnt_q   <= cnt_q + 1'b1;
                        end else if (scl_fall && cnt_q == CNT_FULL) begin
                            cnt_q     <= '0;
                            sda_low_o <= (state_q == ST_ADDR) ? match : 1'b1;
                        end
                    end
                    ST_ACK_A: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if (shreg_q[0]) begin
                                shreg_q   <= rd_val;
                                sda_low_o <= ~rd_val[BYTE_W-1];
                            end else begin
                                sda_low_o <= 1'b0;
                            end
                        end
                    end
                    ST_ACK_W: begin
                        if (scl_rise) wr_stb_o <= 1'b1;
                        if (scl_fall) sda_low_o <= 1'b0;
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (cnt_q == CNT_LAST) begin
                                sda_low_o <= 1'b0;
                            end else begin
                                shreg_q   <= {shreg_q[BYTE_W-2:0], 1'b0};
                                sda_low_o <= ~shreg_q[BYTE_W-2];
                                cnt_q     <= cnt_q + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign wr_tgt_o  = shreg_q[BYTE_W-1];
    assign wr_bits_o = shreg_q[IO_N-1:0];
    assign state_o   = state_q;
endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank
    import smbcfg_pkg::*;
#(
    parameter logic RST_OFF = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb_i,
    input  logic            wr_tgt_i,
    input  logic [IO_N-1:0] wr_bits_i,
    input  logic            hold_sel_i,
    input  logic            therm_i,
    output logic [IO_N-1:0] out_low_o
);
    // slot 0 = hold, slot 1 = normal
    for (genvar g = 0; g < 2; g++) begin : g_slot
        logic [IO_N-1:0] bits_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               bits_q <= {IO_N{RST_OFF}};
            else if (wr_stb_i && (wr_tgt_i == 1'(g))) bits_q <= wr_bits_i;
        end
    end

    logic [IO_N-1:0] sel_bits;
    assign sel_bits  = hold_sel_i ? g_slot[1].bits_q : g_slot[0].bits_q;
    assign out_low_o = therm_i ? '0 : ~sel_bits;
endmodule

// File: rtl/smb_dualcfg_slave.sv
module smb_dualcfg_slave
    import smbcfg_pkg::*;
#(
    parameter logic [6:0] ADDR_LOW  = 7'h20,
    parameter logic [6:0] ADDR_MID  = 7'h3C,
    parameter logic [6:0] ADDR_HIGH = 7'h48,
    parameter logic       RST_OFF   = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_drive_low_o,
    input  logic [1:0] addr_sel_i,
    input  logic       hold_sel_i,
    input  logic       therm_i,
    input  logic [2:0] pin_i,
    output logic [2:0] out_low_o
);
    logic [1:0]        line_lvl, line_prv;
    logic [ADDR_W-1:0] own_addr;
    logic              wr_stb, wr_tgt;
    logic [IO_N-1:0]   wr_bits;
    logic [BYTE_W-1:0] rd_val;
    smb_state_e        fsm_state;

    smb_line_sync #(.LINES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({sda_i, scl_i}),
        .lvl_o (line_lvl),
        .prv_o (line_prv)
    );

    // address strap captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) own_addr <= pick_addr(addr_sel_i, ADDR_LOW, ADDR_MID, ADDR_HIGH);
    end

    assign rd_val = {{(BYTE_W-IO_N-1){1'b0}}, therm_i, pin_i};

    smb_byte_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (line_lvl[0]),
        .scl_prv   (line_prv[0]),
        .sda_lvl   (line_lvl[1]),
        .sda_prv   (line_prv[1]),
        .own_addr  (own_addr),
        .rd_val    (rd_val),
        .sda_low_o (sda_drive_low_o),
        .wr_stb_o  (wr_stb),
        .wr_tgt_o  (wr_tgt),
        .wr_bits_o (wr_bits),
        .state_o   (fsm_state)
    );

    smb_cfg_bank #(.RST_OFF(RST_OFF)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb_i   (wr_stb),
        .wr_tgt_i   (wr_tgt),
        .wr_bits_i  (wr_bits),
        .hold_sel_i (hold_sel_i),
        .therm_i    (therm_i),
        .out_low_o  (out_low_o)
    );
endmodule

// File: rtl/smb_dualcfg_slave_chk.sv
module smb_dualcfg_slave_chk
    import smbcfg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       hold_sel_i,
    input logic       therm_i,
    input logic       sda_drive_low_o,
    input logic [2:0] out_low_o,
    input smb_state_e state,
    input logic       wr_stb
);
    // R9: thermal fault releases every line
    a_r9_therm_releases: assert property (@(posedge clk) disable iff (!rst_n)
        therm_i |-> (out_low_o == 3'b000));

    // R10: SDA drive moves only while SCL is low
    a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low_o != $past(sda_drive_low_o)) |-> !scl_i);

    // R2: no drive on SDA while off the bus
    a_r2_silent_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_drive_low_o);

    // R6: commit happens only inside the data acknowledge while SDA is held low
    a_r6_commit_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (state == ST_ACK_W && sda_drive_low_o));

    // R5: lines hold still unless select, fault or a commit moved them
    a_r5_lines_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(hold_sel_i) && $stable(therm_i) && !$past(wr_stb)) |-> $stable(out_low_o));
endmodule

bind smb_dualcfg_slave smb_dualcfg_slave_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_i           (scl_i),
    .hold_sel_i      (hold_sel_i),
    .therm_i         (therm_i),
    .sda_drive_low_o (sda_drive_low_o),
    .out_low_o       (out_low_o),
    .state           (fsm_state),
    .wr_stb          (wr_stb)
);

// File: tb/test_smb_dualcfg_slave.sv
module test_smb_dualcfg_slave;
    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic [1:0] asel = 2'b00;
    logic       hold = 1'b1, therm = 1'b0;
    logic [2:0] pins = 3'b000;
    logic       sda_drv;
    logic [2:0] out_low;
    wire        sda_line = m_sda & ~sda_drv;

    int checks = 0, failures = 0, r10_viol = 0;
    logic [2:0] m_norm, m_susp, pre_out, post_out;
    logic [6:0] own_a;
    logic       prev_drv = 1'b0;

    always #4 clk = ~clk;

    smb_dualcfg_slave i_smb_dualcfg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_drive_low_o(sda_drv), .addr_sel_i(asel), .hold_sel_i(hold),
        .therm_i(therm), .pin_i(pins), .out_low_o(out_low)
    );

    // R10 monitor: any change of the drive while SCL is high
    always @(negedge clk) begin
        if (rst_n && m_scl && (sda_drv !== prev_drv)) r10_viol++;
        prev_drv <= sda_drv;
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_out(input logic th, input logic hs,
                                           input logic [2:0] nb, input logic [2:0] sb);
        return th ? 3'b000 : ~(hs ? nb : sb);
    endfunction

    function automatic logic [6:0] addr_of(input logic [1:0] s);
        return (s == 2'b00) ? 7'h20 : (s == 2'b10) ? 7'h48 : 7'h3C;
    endfunction

    task automatic bus_bit(input logic b, output logic got);
        m_sda = b; wt(H);
        m_scl = 1'b1; wt(H);
        got = sda_line;
        m_scl = 1'b0; wt(H);
    endtask

    task automatic do_start();
        m_sda = 1'b1; wt(H);
        m_scl = 1'b1; wt(H);
        m_sda = 1'b0; wt(H);
        m_scl = 1'b0; wt(H);
    endtask

    task automatic do_stop();
        m_sda = 1'b0; wt(H);
        m_scl = 1'b1; wt(H);
        m_sda = 1'b1; wt(H);
    endtask

    task automatic send8(input logic [7:0] v);
        logic g;
        for (int i = 7; i >= 0; i--) bus_bit(v[i], g);
    endtask

    task automatic write_txn(input logic [6:0] a, input logic [7:0] d, input int nbits,
                             input bit abort_start, output logic a1, output logic a2);
        logic g;
        do_start();
        send8({a, 1'b0});
        bus_bit(1'b1, g); a1 = !g; a2 = 1'b0;
        for (int i = 0; i < nbits; i++) bus_bit(d[7-i], g);
        if (nbits < 8) begin
            if (abort_start) do_start();
            do_stop();
        end else begin
            m_sda = 1'b1; wt(H);
            pre_out = out_low;
            m_scl = 1'b1; wt(H);
            a2 = !sda_line;
            post_out = out_low;
            m_scl = 1'b0; wt(H);
            do_stop();
        end
    endtask

    task automatic read_txn(input logic [6:0] a, output logic a1, output logic [7:0] v);
        logic g;
        do_start();
        send8({a, 1'b1});
        bus_bit(1'b1, g); a1 = !g;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, g); v[i] = g;
        end
        bus_bit(1'b1, g);
        do_stop();
    endtask

    task automatic do_reset(input logic [1:0] s);
        asel = s; rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
        wt(4);
        rst_n = 1'b1; wt(4);
        m_norm = 3'b111; m_susp = 3'b111; own_a = addr_of(s);
    endtask

    task automatic model_write(input logic [7:0] d);
        if (d[7]) m_norm = d[2:0];
        else      m_susp = d[2:0];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic a1, a2;
        logic [7:0] rv;
        int unsigned seed;
        seed = $urandom(32'h5A17);

        // R1 reset state
        do_reset(2'b00);
        chk("R1 out after reset", {5'b0, out_low}, 8'h00);
        chk("R1 sda released", {7'b0, sda_drv}, 8'h00);

        // R4/R6 normal slot write, split acknowledge
        hold = 1'b1;
        write_txn(7'h20, 8'b1_1111_010, 8, 1'b0, a1, a2);
        chk("R2 addr ack", {7'b0, a1}, 8'h01);
        chk("R6 data ack", {7'b0, a2}, 8'h01);
        chk("R6 before ack rise", {5'b0, pre_out}, 8'h00);
        chk("R6 after ack rise", {5'b0, post_out}, 8'h05);
        model_write(8'b1_1111_010);

        // R4 hold-slot write leaves normal slot
        write_txn(7'h20, 8'b0_1111_100, 8, 1'b0, a1, a2);
        model_write(8'b0_1111_100);
        chk("R4 normal untouched", {5'b0, out_low}, {5'b0, exp_out(therm, hold, m_norm, m_susp)});
        hold = 1'b0; wt(1);
        chk("R5 hold slot drives", {5'b0, out_low}, 8'h03);
        hold = 1'b1; wt(1);
        chk("R5 normal slot drives", {5'b0, out_low}, 8'h05);

        // R9 thermal release
        therm = 1'b1; wt(1);
        chk("R9 therm releases", {5'b0, out_low}, 8'h00);
        therm = 1'b0; wt(1);

        // R7 aborted writes
        write_txn(7'h20, 8'b1_0000_000, 5, 1'b0, a1, a2);
        chk("R7 stop abort", {5'b0, out_low}, {5'b0, exp_out(therm, hold, m_norm, m_susp)});
        write_txn(7'h20, 8'b0_0000_000, 3, 1'b1, a1, a2);
        hold = 1'b0; wt(1);
        chk("R7 start abort", {5'b0, out_low}, {5'b0, exp_out(therm, hold, m_norm, m_susp)});
        hold = 1'b1;

        // R2 wrong address
        write_txn(7'h21, 8'b1_0000_000, 8, 1'b0, a1, a2);
        chk("R2 no ack wrong addr", {6'b0, a1, a2}, 8'h00);
        chk("R2 wrong addr ignored", {5'b0, out_low}, {5'b0, exp_out(therm, hold, m_norm, m_susp)});
        read_txn(7'h3C, a1, rv);
        chk("R2 wrong addr read", rv, 8'hFF);

        // R8 read back, not latched
        pins = 3'b101; therm = 1'b0;
        read_txn(7'h20, a1, rv);
        chk("R8 read pins", rv, 8'h05);
        pins = 3'b010; therm = 1'b1;
        read_txn(7'h20, a1, rv);
        chk("R8 read therm live", rv, 8'h0A);
        therm = 1'b0;

        // R3 address strap
        asel = 2'b10; wt(2);
        read_txn(7'h20, a1, rv);
        chk("R3 strap held after reset", {7'b0, a1}, 8'h01);
        read_txn(7'h48, a1, rv);
        chk("R3 new strap ignored", {7'b0, a1}, 8'h00);
        do_reset(2'b10);
        chk("R1 reset again", {5'b0, out_low}, 8'h00);
        read_txn(7'h48, a1, rv);
        chk("R3 high strap", {7'b0, a1}, 8'h01);
        do_reset(2'b01);
        read_txn(7'h3C, a1, rv);
        chk("R3 floating strap", {7'b0, a1}, 8'h01);
        do_reset(2'b11);
        read_txn(7'h3C, a1, rv);
        chk("R3 code 11 as floating", {7'b0, a1}, 8'h01);

        // random mix
        for (int n = 0; n < 40; n++) begin
            int op;
            logic [6:0] a;
            logic [7:0] d;
            int nb;
            op = $urandom_range(0, 3);
            a = ($urandom_range(0, 4) == 0) ? (own_a ^ 7'h01) : own_a;
            d = 8'($urandom);
            hold = 1'($urandom);
            therm = ($urandom_range(0, 5) == 0);
            pins = 3'($urandom);
            if (op <= 1) begin
                write_txn(a, d, 8, 1'b0, a1, a2);
                chk("R2 rnd ack", {6'b0, a1, a2}, (a == own_a) ? 8'h03 : 8'h00);
                if (a == own_a) begin
                    chk("R6 rnd pre", {5'b0, pre_out}, {5'b0, exp_out(therm, hold, m_norm, m_susp)});
                    model_write(d);
                end
                chk("R4 rnd out", {5'b0, out_low}, {5'b0, exp_out(therm, hold, m_norm, m_susp)});
            end else if (op == 2) begin
                nb = $urandom_range(0, 7);
                write_txn(a, d, nb, 1'($urandom), a1, a2);
                chk("R7 rnd abort", {5'b0, out_low}, {5'b0, exp_out(therm, hold, m_norm, m_susp)});
            end else begin
                read_txn(a, a1, rv);
                chk("R8 rnd read", rv, (a == own_a) ? {4'b0, therm, pins} : 8'hFF);
            end
            hold = ~hold; wt(1);
            chk("R5 rnd select", {5'b0, out_low}, {5'b0, exp_out(therm, hold, m_norm, m_susp)});
        end

        chk("R10 drive changes with SCL high", 8'(r10_viol), 8'h00);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule